// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps the time of day and the calendar in packed BCD and moves them forward by one second on each pulse of a 1 Hz tick input. The running counters are private. The host sees a second copy of them: a bank of byte registers that can be read and written like ordinary memory. The block refreshes this copy from the counters once per second. It handles seconds, minutes, 24-hour hours, day of week (1 to 7), date, month, a two-digit year and a separate century byte. Month lengths of 30 and 31 days are applied, and February follows the divisible-by-four leap rule.

A control byte decides when the visible copy changes. While the freeze bit (bit 6) is set, the copy is not refreshed, so a multi-byte read stays coherent. The counters keep running, and any refresh that was held back is applied as soon as the bit clears. While the write-hold bit (bit 7) is set, the host can write a new time into the copy and no refresh overwrites it. Clearing bit 7 loads the counters from the copy. Bits 5:0 store a calibration value, which is held for other logic and has no effect on timekeeping here.

A sequencer with four states performs every update. ST_IDLE waits. It goes to ST_LOAD when a load is pending, otherwise to ST_ADVANCE when a tick is pending, otherwise to ST_PUBLISH when a held-back refresh can now be applied. ST_ADVANCE steps the counters and always goes on to ST_PUBLISH. ST_PUBLISH copies the counters into the visible bank, or records that a refresh is still owed if a hold bit is set, and then returns to ST_IDLE. ST_LOAD copies the visible bank into the counters, cancels any owed refresh and returns to ST_IDLE.

Top module: `rtc_calendar_bank`

## Requirements
- R1: After reset the bank reads as follows: control 0x00, seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01, year 0x00, century 0x20.
- R2: A one-cycle pulse on `tick_1hz` advances the time by one second. The visible bytes show the new value within three clock edges of the pulse.
- R3: Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: Day of week counts 0x01 to 0x07 and returns to 0x01 at midnight.
- R5: At midnight the date returns to 0x01 and the month advances after day 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after day 0x31 in all other months except February.
- R6: February ends at day 0x29 when the year value is divisible by four (0x00 included), and at day 0x28 otherwise.
- R7: The year wraps from 0x99 to 0x00 and advances the century byte in BCD. The year carries across BCD digits (0x49 to 0x50).
- R8: While control bit 6 is set, the visible bytes do not change, but the counters keep advancing. When the bit clears, the visible bytes show the current counter value, including every second that passed during the freeze.
- R9: While control bit 7 is set, host writes to the time bytes persist across ticks. Writing control with bit 7 going from 1 to 0 loads the counters from the visible bytes, and later ticks count on from the loaded value.
- R10: Control bits 5:0 read back as written and do not change how time advances.
- R11: Address map: index 0 is control, and indexes 1 to 8 are seconds, minutes, hours, day of week, date, month, year and century. Other indexes read 0x00, and writes to them change nothing.
- R12: With control at 0x00, a host write to a time byte can be read back at once. It does not reach the counters, and the next refresh replaces it with the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W (4) | Register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |

## Verification
The bench uses the default parameters: a 4-bit index and a reset century of 0x20. The 4-bit index exposes seven unused locations, 9 to 15, so the bench can check that they are ignored. The bench places the counters directly at each calendar edge through the write-hold load path, so one tick reaches month ends, February in leap and common years, and the year and century wrap without counting real time. Fixed state-machine latency lets every visible update be sampled a few cycles after its tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADVANCE,
        ST_PUBLISH,
        ST_LOAD
    } seq_state_t;

    localparam int CLK_BYTES   = 8;
    localparam int CTRL_WR_BIT = 7;
    localparam int CTRL_RD_BIT = 6;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
    parameter logic [7:0] WRAP = 8'h00
) (
    input  logic [7:0] val,
    input  logic [7:0] lim,
    input  logic       en,
    output logic [7:0] nxt,
    output logic       carry
);
    import rtc_cal_pkg::*;

    logic at_end;

    always_comb begin
        at_end = (val >= lim);
        if (!en)         nxt = val;
        else if (at_end) nxt = WRAP;
        else             nxt = bcd_inc(val);
        carry = en && at_end;
    end

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_day
);
    logic [1:0] yr_mod4;
    logic       leap;

    always_comb begin
        yr_mod4 = {year[4], 1'b0} + year[1:0];
        leap    = (yr_mod4 == 2'd0);
        unique case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_advance.sv
module rtc_advance (
    input  logic [63:0] cur,
    output logic [63:0] nxt
);
    logic [7:0] mlen;
    logic c_sec, c_min, c_hour, c_date, c_month, c_year, c_cent;
    logic [7:0] dow_cur, dow_nxt;

    rtc_bcd_step #(.WRAP(8'h00)) u_sec (
        .val(cur[7:0]),   .lim(8'h59), .en(1'b1),
        .nxt(nxt[7:0]),   .carry(c_sec));
    rtc_bcd_step #(.WRAP(8'h00)) u_min (
        .val(cur[15:8]),  .lim(8'h59), .en(c_sec),
        .nxt(nxt[15:8]),  .carry(c_min));
    rtc_bcd_step #(.WRAP(8'h00)) u_hour (
        .val(cur[23:16]), .lim(8'h23), .en(c_min),
        .nxt(nxt[23:16]), .carry(c_hour));

    rtc_month_len u_mlen (
        .month(cur[47:40]), .year(cur[55:48]), .last_day(mlen));

    rtc_bcd_step #(.WRAP(8'h01)) u_date (
        .val(cur[39:32]), .lim(mlen),  .en(c_hour),
        .nxt(nxt[39:32]), .carry(c_date));
    rtc_bcd_step #(.WRAP(8'h01)) u_month (
        .val(cur[47:40]), .lim(8'h12), .en(c_date),
        .nxt(nxt[47:40]), .carry(c_month));
    rtc_bcd_step #(.WRAP(8'h00)) u_year (
        .val(cur[55:48]), .lim(8'h99), .en(c_month),
        .nxt(nxt[55:48]), .carry(c_year));
    rtc_bcd_step #(.WRAP(8'h00)) u_cent (
        .val(cur[63:56]), .lim(8'h99), .en(c_year),
        .nxt(nxt[63:56]), .carry(c_cent));

    // Day of week runs alongside the date, 1..7
    assign dow_cur = cur[31:24];
    always_comb begin
        if (!c_hour)                                dow_nxt = dow_cur;
        else if (dow_cur >= 8'h07 || dow_cur == 0)  dow_nxt = 8'h01;
        else                                        dow_nxt = dow_cur + 8'h01;
    end
    assign nxt[31:24] = dow_nxt;

endmodule

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load_req,
    input  logic hold,
    output logic do_adv,
    output logic do_pub,
    output logic do_load
);
    import rtc_cal_pkg::*;

    seq_state_t state_q, state_d;
    logic tick_pend_q, tick_pend_d;
    logic load_pend_q, load_pend_d;
    logic pub_pend_q,  pub_pend_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            tick_pend_q <= 1'b0;
            load_pend_q <= 1'b0;
            pub_pend_q  <= 1'b0;
        end else begin
            state_q     <= state_d;
            tick_pend_q <= tick_pend_d;
            load_pend_q <= load_pend_d;
            pub_pend_q  <= pub_pend_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        do_adv      = 1'b0;
        do_pub      = 1'b0;
        do_load     = 1'b0;
        tick_pend_d = tick_pend_q | tick;
        load_pend_d = load_pend_q | load_req;
        pub_pend_d  = pub_pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_pend_q) begin
                    state_d = ST_LOAD;
                end else if (tick_pend_d) begin
                    state_d     = ST_ADVANCE;
                    tick_pend_d = 1'b0;
                end else if (pub_pend_q && !hold) begin
                    state_d = ST_PUBLISH;
                end
            end
            ST_ADVANCE: begin
                do_adv  = 1'b1;
                state_d = ST_PUBLISH;
            end
            ST_PUBLISH: begin
                if (hold) begin
                    pub_pend_d = 1'b1;
                end else begin
                    do_pub     = 1'b1;
                    pub_pend_d = 1'b0;
                end
                state_d = ST_IDLE;
            end
            ST_LOAD: begin
                do_load     = 1'b1;
                load_pend_d = load_req;
                pub_pend_d  = 1'b0;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_adv_to_pub_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ADVANCE |=> state_q == ST_PUBLISH);
    assert_one_action_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_adv, do_pub, do_load}));
    assert_load_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && load_pend_q) |=> state_q == ST_LOAD);

endmodule

// File: rtl/rtc_calendar_bank.sv
module rtc_calendar_bank #(
    parameter int         ADDR_W      = 4,
    parameter logic [7:0] RST_CENTURY = 8'h20,
    parameter logic [7:0] RST_YEAR    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata
);
    import rtc_cal_pkg::*;

    localparam int          NBYTES   = CLK_BYTES;
    localparam int          TW       = 8 * NBYTES;
    localparam logic [TW-1:0] RST_TIME =
        {RST_CENTURY, RST_YEAR, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    logic [7:0]    ctrl_q;
    logic [TW-1:0] cnt_q, cnt_nxt, vis_bus;
    logic          do_adv, do_pub, do_load;
    logic          ctrl_wr, load_req, hold;

    assign ctrl_wr  = host_wr && (host_addr == '0);
    assign load_req = ctrl_wr && ctrl_q[CTRL_WR_BIT] && !host_wdata[CTRL_WR_BIT];
    assign hold     = ctrl_q[CTRL_WR_BIT] | ctrl_q[CTRL_RD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= 8'h00;
        else if (ctrl_wr) ctrl_q <= host_wdata;
    end

    rtc_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .load_req(load_req),
        .hold(hold), .do_adv(do_adv), .do_pub(do_pub), .do_load(do_load));

    rtc_advance u_adv (.cur(cnt_q), .nxt(cnt_nxt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= RST_TIME;
        else if (do_load) cnt_q <= vis_bus;
        else if (do_adv)  cnt_q <= cnt_nxt;
    end

    // Visible bank: host write wins over a refresh in the same cycle
    for (genvar i = 0; i < NBYTES; i++) begin : g_vis
        logic [7:0] byte_q;
        logic       sel;
        assign sel = host_wr && (host_addr == ADDR_W'(i + 1));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      byte_q <= RST_TIME[8*i +: 8];
            else if (sel)    byte_q <= host_wdata;
            else if (do_pub) byte_q <= cnt_q[8*i +: 8];
        end
        assign vis_bus[8*i +: 8] = byte_q;
    end

    always_comb begin
        host_rdata = 8'h00;
        if (host_addr == '0) host_rdata = ctrl_q;
        for (int i = 0; i < NBYTES; i++) begin
            if (host_addr == ADDR_W'(i + 1)) host_rdata = vis_bus[8*i +: 8];
        end
    end

    assert_advance_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_adv |=> cnt_q != $past(cnt_q));
    assert_freeze_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_RD_BIT] && !host_wr) |=> $stable(vis_bus));
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_WR_BIT] && !host_wr) |=> $stable(vis_bus));
    assert_load_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> cnt_q == $past(vis_bus));
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr > ADDR_W'(NBYTES)) |-> host_rdata == 8'h00);

endmodule

// File: tb/rtc_calendar_bank_bench.sv
module rtc_calendar_bank_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       host_wr = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar_bank u_rtc_calendar_bank (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata));

    // Time word: century, year, month, date, dow, hour, minute, second
    typedef struct packed {
        logic [7:0]  tag;
        logic [63:0] start;
        logic [63:0] expect_t;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{8'd2,  64'h20250614_06123456, 64'h20250614_06123457}, // R2 plain second
        '{8'd3,  64'h20250614_06105959, 64'h20250614_06110000}, // R3 hour carry
        '{8'd3,  64'h20250614_06000059, 64'h20250614_06000100}, // R3 minute carry
        '{8'd4,  64'h20250515_07235959, 64'h20250516_01000000}, // R4 dow 7 to 1
        '{8'd4,  64'h20250515_03235959, 64'h20250516_04000000}, // R4 dow step
        '{8'd5,  64'h20250430_02235959, 64'h20250501_03000000}, // R5 30-day month
        '{8'd5,  64'h20250131_05235959, 64'h20250201_06000000}, // R5 31-day month
        '{8'd5,  64'h20251130_01235959, 64'h20251201_02000000}, // R5 November
        '{8'd5,  64'h20250830_04235959, 64'h20250831_05000000}, // R5 no early wrap
        '{8'd6,  64'h20240228_03235959, 64'h20240229_04000000}, // R6 leap year
        '{8'd6,  64'h20240229_04235959, 64'h20240301_05000000}, // R6 leap end
        '{8'd6,  64'h20230228_02235959, 64'h20230301_03000000}, // R6 common year
        '{8'd6,  64'h20000228_01235959, 64'h20000229_02000000}, // R6 year 00
        '{8'd6,  64'h20100228_06235959, 64'h20100301_07000000}, // R6 year 10
        '{8'd7,  64'h20991231_07235959, 64'h21000101_01000000}, // R7 century
        '{8'd7,  64'h20491231_02235959, 64'h20500101_03000000}  // R7 BCD year
    };

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 4'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        host_addr = 4'(a);
        #(CLK_PERIOD/4);
        d = host_rdata;
    endtask

    task automatic read_time(output logic [63:0] t);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) begin
            rd(i + 1, b);
            t[8*i +: 8] = b;
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic load_time(input logic [63:0] t);
        wr(0, 8'h80);
        for (int i = 0; i < 8; i++) wr(i + 1, t[8*i +: 8]);
        wr(0, 8'h00);
        repeat (4) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] t;
        logic [7:0]  b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset contents
        rd(0, b);
        check("R1 ctrl", {56'd0, b}, 64'h0);
        read_time(t);
        check("R1 time", t, 64'h20000101_01000000);

        // Table walk: R2..R7
        foreach (VEC[k]) begin
            load_time(VEC[k].start);
            pulse_tick();
            read_time(t);
            check($sformatf("R%0d vector %0d", VEC[k].tag, k), t, VEC[k].expect_t);
        end

        // R8 freeze: copy stays, counters keep running
        load_time(64'h20250614_06080010);
        wr(0, 8'h40);
        pulse_tick(); pulse_tick(); pulse_tick();
        read_time(t);
        check("R8 frozen", t, 64'h20250614_06080010);
        wr(0, 8'h00);
        repeat (4) @(negedge clk);
        read_time(t);
        check("R8 released", t, 64'h20250614_06080013);

        // R9 write hold and load on release
        wr(0, 8'h80);
        for (int i = 0; i < 8; i++) wr(i + 1, 8'(64'h20300315_05184520 >> (8*i)));
        pulse_tick();
        read_time(t);
        check("R9 held", t, 64'h20300315_05184520);
        wr(0, 8'h00);
        repeat (4) @(negedge clk);
        pulse_tick();
        read_time(t);
        check("R9 loaded", t, 64'h20300315_05184521);

        // R10 calibration field
        wr(0, 8'h25);
        rd(0, b);
        check("R10 ctrl 25", {56'd0, b}, 64'h25);
        pulse_tick();
        read_time(t);
        check("R10 time", t, 64'h20300315_05184522);
        wr(0, 8'h3F);
        rd(0, b);
        check("R10 ctrl 3F", {56'd0, b}, 64'h3F);
        wr(0, 8'h00);

        // R11 unmapped locations
        wr(9, 8'h55);
        rd(9, b);
        check("R11 idx9", {56'd0, b}, 64'h0);
        wr(15, 8'hAA);
        rd(15, b);
        check("R11 idx15", {56'd0, b}, 64'h0);
        read_time(t);
        check("R11 untouched", t, 64'h20300315_05184522);

        // R12 direct write to copy, overwritten at refresh
        wr(1, 8'h33);
        rd(1, b);
        check("R12 readback", {56'd0, b}, 64'h33);
        pulse_tick();
        read_time(t);
        check("R12 refresh", t, 64'h20300315_05184523);

        finish_run();
    end

endmodule